// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the fetch stage of a small processor core. It steers the program counter and status register whenever normal flow has to be left or resumed. It sorts incoming requests into three classes: reset, synchronous fault, and external interrupt. It then builds the complete state change for the winning request within one clock. On entry it copies the interrupted PC and SR into dedicated shadow registers. It forces the status word into privileged, alternate-bank, blocked operation. It records the 12-bit cause in either the fault-cause or the interrupt-cause register, and it emits a new fetch address with a one-cycle load strobe.

A fault is taken at once and abandons the instruction in flight. An interrupt waits until the core signals an instruction boundary. While the block bit of the incoming SR is set, interrupts stay pending and any fault escalates to a reset-class entry. A return strobe puts the saved PC and SR back through the same load strobes. Priority arbitration among interrupt sources, decoding and the register banks themselves live elsewhere.

Top module: `exc_seq_ctrl`

## Requirements
- R1: After the asynchronous reset, pc_load_o and sr_load_o are 0, and pc_o, sr_o, spc_o, ssr_o, exp_evt_o and int_evt_o are all zero.
- R2: A reset request yields, one cycle later, pc_o = 0xA000_0000, sr_o = 0x7000_0000 (bit 30 privileged, bit 29 bank, bit 28 block, all else 0), both strobes high and exp_evt_o = 0x000. spc_o and ssr_o keep their values.
- R3: A fault request with SR bit 28 clear is taken whatever insn_end_i is. One cycle later spc_o = pc_i, ssr_o = sr_i, sr_o = sr_i with bits 30:28 set, pc_o = vbr_i + 0x100, exp_evt_o = fault code, and both strobes are high.
- R4: An interrupt request with insn_end_i = 1 and SR bit 28 clear saves the context as in R3. It sets pc_o = vbr_i + 0x600 and int_evt_o = interrupt code, and it leaves exp_evt_o unchanged.
- R5: An interrupt request while insn_end_i = 0 has no effect: no strobe, and no change to the shadow or cause registers.
- R6: An interrupt request while SR bit 28 is set has no effect, even at an instruction boundary.
- R7: A fault request while SR bit 28 is set is handled as a reset-class entry: pc_o = 0xA000_0000 and sr_o = 0x7000_0000. exp_evt_o becomes 0x020, and spc_o and ssr_o are not touched.
- R8: Priority is reset first, then fault, then interrupt, then return. A fault and an interrupt in the same cycle take the fault and leave int_evt_o unchanged.
- R9: A return request with no other request selected yields, one cycle later, pc_o = spc_o, sr_o = ssr_o and both strobes high.
- R10: Strobes last one cycle and are low whenever no request was selected. pc_o and sr_o then hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the current instruction |
| sr_i | input | 32 | Current status register |
| vbr_i | input | 32 | Vector base address |
| insn_end_i | input | 1 | Current instruction completes this cycle |
| rst_req_i | input | 1 | Reset-class request |
| exc_req_i | input | 1 | Synchronous fault request |
| exc_code_i | input | 12 | Fault cause code |
| irq_req_i | input | 1 | Interrupt request (level, held until taken) |
| irq_code_i | input | 12 | Interrupt cause code |
| rte_i | input | 1 | Return-from-exception strobe |
| pc_o | output | 32 | New fetch address |
| pc_load_o | output | 1 | Load pc_o into PC |
| sr_o | output | 32 | New status word |
| sr_load_o | output | 1 | Load sr_o into SR |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved SR |
| exp_evt_o | output | 12 | Fault cause register |
| int_evt_o | output | 12 | Interrupt cause register |

## Verification
The block registers all of its results, so every result of a request sampled on a rising edge is due straight after that edge. This covers the vector, new SR, strobes, shadow registers and cause registers. The driver changes inputs on falling edges and tags each expectation with the cycle count of the edge that consumes it. The monitor compares on the next falling edge only the items whose due cycle has arrived, so it never samples mid-edge or a cycle early. Requests that must be ignored are checked in that same cycle, through the absent strobes and the unchanged shadow and cause registers.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SR_MD_BIT = 30;
  localparam int SR_RB_BIT = 29;
  localparam int SR_BL_BIT = 28;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_RESET = 3'd1,
    EV_ESC   = 3'd2,
    EV_GEN   = 3'd3,
    EV_IRQ   = 3'd4,
    EV_RTE   = 3'd5
  } ev_kind_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic     rst_req_i,
  input  logic     exc_req_i,
  input  logic     irq_req_i,
  input  logic     insn_end_i,
  input  logic     rte_i,
  input  logic     bl_i,
  output ev_kind_e kind_o
);
  logic irq_ok;
  assign irq_ok = irq_req_i && insn_end_i && !bl_i;

  always_comb begin
    kind_o = EV_NONE;
    if (rst_req_i)               kind_o = EV_RESET;
    else if (exc_req_i && bl_i)  kind_o = EV_ESC;   // fault under block escalates
    else if (exc_req_i)          kind_o = EV_GEN;
    else if (irq_ok)             kind_o = EV_IRQ;
    else if (rte_i)              kind_o = EV_RTE;
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0] GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0] IRQ_OFS   = 32'h0000_0600
) (
  input  ev_kind_e        kind_i,
  input  logic [XLEN-1:0] vbr_i,
  input  logic [XLEN-1:0] spc_i,
  output logic [XLEN-1:0] target_o
);
  always_comb begin
    unique case (kind_i)
      EV_RESET, EV_ESC: target_o = RESET_VEC;
      EV_GEN:           target_o = vbr_i + GEN_OFS;
      EV_IRQ:           target_o = vbr_i + IRQ_OFS;
      EV_RTE:           target_o = spc_i;
      default:          target_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctx_store.sv
module exc_ctx_store
  import exc_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter int                CODE_W   = 12,
  parameter logic [CODE_W-1:0] RST_CODE = 12'h000,
  parameter logic [CODE_W-1:0] ESC_CODE = 12'h020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ev_kind_e          kind_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [CODE_W-1:0] irq_code_i,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] exp_evt_o,
  output logic [CODE_W-1:0] int_evt_o
);
  logic save_ctx;
  assign save_ctx = (kind_i == EV_GEN) || (kind_i == EV_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spc_o <= '0;
      ssr_o <= '0;
    end else if (save_ctx) begin
      spc_o <= pc_i;
      ssr_o <= sr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_evt_o <= '0;
      int_evt_o <= '0;
    end else begin
      unique case (kind_i)
        EV_RESET: exp_evt_o <= RST_CODE;
        EV_ESC:   exp_evt_o <= ESC_CODE;
        EV_GEN:   exp_evt_o <= exc_code_i;
        EV_IRQ:   int_evt_o <= irq_code_i;
        default:  ;
      endcase
    end
  end

  assert_irq_keeps_exp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_IRQ) |=> (exp_evt_o == $past(exp_evt_o)));
  assert_gen_keeps_int_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == EV_GEN) |=> (int_evt_o == $past(int_evt_o)));
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_pkg::*;
#(
  parameter int                XLEN      = 32,
  parameter int                CODE_W    = 12,
  parameter logic [XLEN-1:0]   RESET_VEC = 32'hA000_0000,
  parameter logic [XLEN-1:0]   GEN_OFS   = 32'h0000_0100,
  parameter logic [XLEN-1:0]   IRQ_OFS   = 32'h0000_0600,
  parameter logic [CODE_W-1:0] RST_CODE  = 12'h000,
  parameter logic [CODE_W-1:0] ESC_CODE  = 12'h020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   sr_i,
  input  logic [XLEN-1:0]   vbr_i,
  input  logic              insn_end_i,
  input  logic              rst_req_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              rte_i,
  output logic [XLEN-1:0]   pc_o,
  output logic              pc_load_o,
  output logic [XLEN-1:0]   sr_o,
  output logic              sr_load_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [CODE_W-1:0] exp_evt_o,
  output logic [CODE_W-1:0] int_evt_o
);
  localparam logic [XLEN-1:0] PRIV_MASK =
    (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_BL_BIT);

  ev_kind_e        kind;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] sr_next;

  exc_arbiter u_arb (
    .rst_req_i (rst_req_i),
    .exc_req_i (exc_req_i),
    .irq_req_i (irq_req_i),
    .insn_end_i(insn_end_i),
    .rte_i     (rte_i),
    .bl_i      (sr_i[SR_BL_BIT]),
    .kind_o    (kind)
  );

  exc_vector_gen #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .GEN_OFS(GEN_OFS), .IRQ_OFS(IRQ_OFS)
  ) u_vec (
    .kind_i  (kind),
    .vbr_i   (vbr_i),
    .spc_i   (spc_o),
    .target_o(target)
  );

  exc_ctx_store #(
    .XLEN(XLEN), .CODE_W(CODE_W), .RST_CODE(RST_CODE), .ESC_CODE(ESC_CODE)
  ) u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .pc_i      (pc_i),
    .sr_i      (sr_i),
    .exc_code_i(exc_code_i),
    .irq_code_i(irq_code_i),
    .spc_o     (spc_o),
    .ssr_o     (ssr_o),
    .exp_evt_o (exp_evt_o),
    .int_evt_o (int_evt_o)
  );

  always_comb begin
    unique case (kind)
      EV_RESET, EV_ESC: sr_next = PRIV_MASK;
      EV_GEN, EV_IRQ:   sr_next = sr_i | PRIV_MASK;
      EV_RTE:           sr_next = ssr_o;
      default:          sr_next = sr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o      <= '0;
      sr_o      <= '0;
      pc_load_o <= 1'b0;
      sr_load_o <= 1'b0;
    end else begin
      pc_load_o <= (kind != EV_NONE);
      sr_load_o <= (kind != EV_NONE);
      sr_o      <= sr_next;
      if (kind != EV_NONE) pc_o <= target;
    end
  end

  assert_reset_vec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (pc_load_o && pc_o == RESET_VEC && sr_o == PRIV_MASK && $stable(spc_o)));
  assert_fault_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && !rst_req_i && !sr_i[SR_BL_BIT])
      |=> (pc_load_o && spc_o == $past(pc_i) && ssr_o == $past(sr_i)
           && sr_o[SR_BL_BIT] && sr_o[SR_MD_BIT] && sr_o[SR_RB_BIT]));
  assert_irq_wait_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !insn_end_i && !rst_req_i && !exc_req_i && !rte_i)
      |=> (!pc_load_o && $stable(int_evt_o)));
  assert_irq_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && sr_i[SR_BL_BIT] && !rst_req_i && !exc_req_i && !rte_i)
      |=> (!sr_load_o && $stable(spc_o)));
  assert_escalate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_i && sr_i[SR_BL_BIT]) |=> (pc_o == RESET_VEC && $stable(ssr_o)));
  assert_rte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rte_i && !rst_req_i && !exc_req_i && !(irq_req_i && insn_end_i && !sr_i[SR_BL_BIT]))
      |=> (pc_o == $past(spc_o) && sr_o == $past(ssr_o)));
  assert_strobe_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o == sr_load_o));
endmodule

// File: tb/exc_seq_ctrl_tb.sv
module exc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, sr, vbr;
  logic        insn_end, rst_req, exc_req, irq_req, rte;
  logic [11:0] exc_code, irq_code;
  logic [31:0] pc_o, sr_o, spc_o, ssr_o;
  logic        pc_load_o, sr_load_o;
  logic [11:0] exp_evt_o, int_evt_o;

  always #10 clk = ~clk;  // 50 MHz

  exc_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .sr_i(sr), .vbr_i(vbr),
    .insn_end_i(insn_end), .rst_req_i(rst_req), .exc_req_i(exc_req),
    .exc_code_i(exc_code), .irq_req_i(irq_req), .irq_code_i(irq_code),
    .rte_i(rte), .pc_o(pc_o), .pc_load_o(pc_load_o), .sr_o(sr_o),
    .sr_load_o(sr_load_o), .spc_o(spc_o), .ssr_o(ssr_o),
    .exp_evt_o(exp_evt_o), .int_evt_o(int_evt_o)
  );

  typedef struct {
    int          due;
    string       tag;
    logic        ld;
    logic [31:0] pc, sr, spc, ssr;
    logic [11:0] exp_e, int_e;
  } exp_t;

  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_pc = 0, m_sr = 0, m_spc = 0, m_ssr = 0;
  logic [11:0] m_exp = 0, m_int = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, ex);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "pc_load", {31'b0, pc_load_o}, {31'b0, e.ld});
      chk(e.tag, "sr_load", {31'b0, sr_load_o}, {31'b0, e.ld});
      chk(e.tag, "pc", pc_o, e.pc);
      chk(e.tag, "sr", sr_o, e.sr);
      chk(e.tag, "spc", spc_o, e.spc);
      chk(e.tag, "ssr", ssr_o, e.ssr);
      chk(e.tag, "exp_evt", {20'b0, exp_evt_o}, {20'b0, e.exp_e});
      chk(e.tag, "int_evt", {20'b0, int_evt_o}, {20'b0, e.int_e});
    end
  end

  // driver: apply at falling edge, predict, push expectation due after next rising edge
  task automatic step(string tag, bit r, bit e, logic [11:0] ec, bit i, logic [11:0] ic,
                      bit ie, bit rt, logic [31:0] p, logic [31:0] s, logic [31:0] v);
    exp_t x;
    bit bl;
    @(negedge clk);
    rst_req = r; exc_req = e; exc_code = ec; irq_req = i; irq_code = ic;
    insn_end = ie; rte = rt; pc = p; sr = s; vbr = v;
    bl = s[28];
    x.ld = 1'b1;
    if (r) begin
      m_pc = 32'hA000_0000; m_sr = 32'h7000_0000; m_exp = 12'h000;
    end else if (e && bl) begin
      m_pc = 32'hA000_0000; m_sr = 32'h7000_0000; m_exp = 12'h020;
    end else if (e) begin
      m_spc = p; m_ssr = s; m_sr = s | 32'h7000_0000; m_pc = v + 32'h100; m_exp = ec;
    end else if (i && ie && !bl) begin
      m_spc = p; m_ssr = s; m_sr = s | 32'h7000_0000; m_pc = v + 32'h600; m_int = ic;
    end else if (rt) begin
      m_pc = m_spc; m_sr = m_ssr;
    end else x.ld = 1'b0;
    x.due = cyc + 1; x.tag = tag;
    x.pc = m_pc; x.sr = m_sr; x.spc = m_spc; x.ssr = m_ssr;
    x.exp_e = m_exp; x.int_e = m_int;
    q.push_back(x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    {rst_req, exc_req, irq_req, insn_end, rte} = '0;
    exc_code = '0; irq_code = '0; pc = '0; sr = '0; vbr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc_load", {31'b0, pc_load_o}, 32'd0);
    chk("R1", "pc", pc_o, 32'd0);
    chk("R1", "sr", sr_o, 32'd0);
    chk("R1", "spc", spc_o, 32'd0);
    chk("R1", "evt", {8'b0, exp_evt_o, int_evt_o}, 32'd0);
    rst_n = 1'b1;
    //     tag   rst exc code    irq code    end rte pc            sr            vbr
    step("R3", 0, 1, 12'h0e0, 0, 12'h000, 0, 0, 32'h0000_1234, 32'h0000_00f0, 32'h8000_0000);
    step("R2", 1, 0, 12'h000, 0, 12'h000, 0, 0, 32'h0000_5550, 32'h0000_0001, 32'h8000_0000);
    step("R10", 0, 0, 12'h000, 0, 12'h000, 1, 0, 32'h0000_2000, 32'h0000_0000, 32'h8000_0000);
    step("R5", 0, 0, 12'h000, 1, 12'h3c0, 0, 0, 32'h0000_2002, 32'h0000_0000, 32'h8000_0000);
    step("R4", 0, 0, 12'h000, 1, 12'h3c0, 1, 0, 32'h0000_2004, 32'h0000_0030, 32'h8100_0000);
    step("R6", 0, 0, 12'h000, 1, 12'h400, 1, 0, 32'h0000_3000, 32'h1000_0000, 32'h8100_0000);
    step("R7", 0, 1, 12'h1e0, 0, 12'h000, 1, 0, 32'h0000_3002, 32'h5000_0000, 32'h8100_0000);
    step("R8", 0, 1, 12'h160, 1, 12'h5a0, 1, 0, 32'h0000_4000, 32'h0000_0002, 32'h9000_0000);
    step("R8", 1, 1, 12'h160, 1, 12'h5a0, 1, 1, 32'h0000_4100, 32'h0000_0000, 32'h9000_0000);
    step("R9", 0, 0, 12'h000, 0, 12'h000, 1, 1, 32'h0000_4200, 32'h7000_0000, 32'h9000_0000);
    step("R10", 0, 0, 12'h000, 0, 12'h000, 1, 0, 32'h0000_4300, 32'h0000_0000, 32'h9000_0000);
    step("R8", 0, 0, 12'h000, 1, 12'h620, 1, 1, 32'h0000_4400, 32'h0000_0000, 32'h9000_0000);
    step("R9", 0, 0, 12'h000, 1, 12'h640, 0, 1, 32'h0000_4500, 32'h1000_0000, 32'h9000_0000);
    step("R3", 0, 1, 12'h0a0, 0, 12'h000, 1, 0, 32'h0000_4600, 32'h0000_0003, 32'hA100_0000);
    step("R10", 0, 0, 12'h000, 0, 12'h000, 0, 0, 32'h0000_4700, 32'h0000_0000, 32'hA100_0000);
    step("R10", 0, 0, 12'h000, 0, 12'h000, 0, 0, 32'h0000_4800, 32'h0000_0000, 32'hA100_0000);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule